// File: doc/BRIEF.md
# SPI Header-Driven Transaction Engine

This block is a SPI master that runs one transaction at a time out of a shared byte buffer. Software fills the buffer through a 32-bit register window: the first two bytes carry a header that names the operation and its byte count, and the transmit payload follows from byte 2. Software then writes a command word that picks one chip-select line and starts the transfer. The start is either immediate or held until an external trigger pulse. The engine shifts bytes MSB first in SPI mode 0. Received bytes are stored back into the buffer from byte 0. The end of a transfer raises a maskable interrupt.

In a read transaction a configurable number of leading bytes is only transmitted. These usually carry a command or an address for the slave, and receiving starts after them. A halt command stops the transfer cleanly at the next byte boundary. A flush command drops the engine back to idle at once. Bit timing comes from an external enable, `bit_tick`: each cycle in which it is high moves SCK by one half-period.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every `spi_cs_n` line is high, `spi_sck` and `spi_mosi` are low, `irq` is low, and both the status word (0x84) and the interrupt status (0x08) read 0.
- R2: With opcode 2 (send), the engine transmits `len` bytes taken from buffer bytes 2 onwards, MSB first. MOSI changes only while SCK is low and is sampled by the slave on the SCK rising edge. The buffer is left unchanged.
- R3: With opcode 3 (receive), the engine first transmits P bytes from buffer bytes 2 onwards, where P is the prepend count in bits 31:24 of the mode word at 0x88. It then clocks `len` further bytes with MOSI held low and stores the received bytes at buffer bytes 0 to len-1.
- R4: With opcode 1 (exchange), byte i sent comes from buffer byte 2+i and byte i received is stored at buffer byte i, for i from 0 to len-1. The prepend count has no effect.
- R5: The header is the little-endian 16-bit value in buffer bytes 0 (low) and 1 (high). Its bits 15:13 are the opcode and bits 12:0 are the length. The buffer is mapped at word addresses 0x200 and up, with byte k in lane k mod 4.
- R6: Command word bits 3:0 select the action: 0 no-op, 1 start now, 2 start on trigger, 3 halt, 4 flush. Bits 14:12 select the chip select. While a transfer runs, exactly that `spi_cs_n` line is low and it stays low until the transfer ends. Bit 0 of the status word at 0x84 reads 1 while a transfer runs.
- R7: A start with an opcode other than 1, 2 or 3, with a length of 0, or with a total byte count above the buffer size minus 2 is rejected. The total is prepend plus length for receive and length otherwise. A rejected start drives no chip select and sets interrupt status bit 1, not bit 0.
- R8: Interrupt status bit 0 at 0x08 is set when an accepted transfer completes. Writing ones to 0x08 clears the matching bits. The mask is at 0x10, 0x0C reads status AND mask, and `irq` is high when that AND is non-zero.
- R9: Command 2 arms the engine with the chosen chip select and sets bit 1 of 0x84. The transfer starts only when `ext_trig` is high while the engine is armed and idle, and the start clears the armed bit.
- R10: Command 3 during a transfer lets the current byte finish, then releases chip select without setting interrupt status bit 0. It also clears the armed bit.
- R11: Command 4 returns the engine to idle in the same cycle: chip select is released, SCK is low, the armed bit is cleared and the byte counters are reset.
- R12: A start command issued while a transfer runs is ignored, and a no-op command has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read (data appears in the next cycle) |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| ext_trig | input | 1 | External start trigger for an armed engine |
| bit_tick | input | 1 | Half-bit enable from the clock generator |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench builds the engine with a 32-byte buffer and 8 chip selects. The small buffer puts the size limit within reach of short runs: a 30-byte send, and a receive of 28 bytes behind a 2-byte prepend, both land exactly on the limit, while one byte more is rejected. The 8 chip selects let the vector table drive several distinct select lines. `bit_tick` is held high, so a byte lasts 16 cycles, and the halt and flush commands can be placed at known points inside a byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_GO    = 4'd1,
        CMD_ARM   = 4'd2,
        CMD_HALT  = 4'd3,
        CMD_FLUSH = 4'd4
    } cmd_e;

    localparam logic [2:0] OP_XCHG = 3'd1;
    localparam logic [2:0] OP_SEND = 3'd2;
    localparam logic [2:0] OP_RECV = 3'd3;

    localparam logic [ADDR_W-1:0] A_INT_ST  = 12'h008;
    localparam logic [ADDR_W-1:0] A_INT_MSD = 12'h00C;
    localparam logic [ADDR_W-1:0] A_INT_MSK = 12'h010;
    localparam logic [ADDR_W-1:0] A_CMD     = 12'h080;
    localparam logic [ADDR_W-1:0] A_STAT    = 12'h084;
    localparam logic [ADDR_W-1:0] A_MODE    = 12'h088;

    // buffer window: addresses 0x200..0x3FF
    localparam logic [2:0] WIN_TAG = 3'b001;

endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
    parameter int BUF_BYTES = 512,
    localparam int BI_W = $clog2(BUF_BYTES),
    localparam int WI_W = BI_W - 2
) (
    input  logic            clk,
    input  logic            bus_we,
    input  logic [WI_W-1:0] bus_widx,
    input  logic [31:0]     bus_wdata,
    input  logic [WI_W-1:0] bus_ridx,
    output logic [31:0]     bus_rdata,
    input  logic            eng_we,
    input  logic [BI_W-1:0] eng_widx,
    input  logic [7:0]      eng_wbyte,
    input  logic [BI_W-1:0] eng_ridx,
    output logic [7:0]      eng_rbyte,
    output logic [15:0]     hdr
);

    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (bus_we) begin
            for (int k = 0; k < 4; k++) begin
                mem[{bus_widx, 2'(k)}] <= bus_wdata[8*k +: 8];
            end
        end
        // engine write is issued last so it wins a same-byte collision
        if (eng_we) begin
            mem[eng_widx] <= eng_wbyte;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign bus_rdata[8*g +: 8] = mem[{bus_ridx, 2'(g)}];
    end

    assign eng_rbyte = mem[eng_ridx];
    assign hdr       = {mem[1], mem[0]};

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int NUM_CS    = 8,
    localparam int BI_W = $clog2(BUF_BYTES),
    localparam int WI_W = BI_W - 2,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic [31:0]       buf_rdata,
    output logic              buf_we,
    output logic [WI_W-1:0]   buf_idx,
    input  logic              busy,
    input  logic              armed,
    input  logic              done_p,
    input  logic              rej_p,
    output logic              cmd_v,
    output logic [3:0]        cmd_code,
    output logic [CS_W-1:0]   cmd_cs,
    output logic [7:0]        prepend,
    output logic [1:0]        int_st
);

    typedef struct packed {
        logic [31:0] rdata;
        logic [1:0]  ist;
        logic [1:0]  msk;
        logic [7:0]  pre;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr, rd, in_win;
    logic [31:0] rmux;

    assign wr     = reg_en && reg_we;
    assign rd     = reg_en && !reg_we;
    assign in_win = (reg_addr[ADDR_W-1:9] == WIN_TAG);

    assign buf_we   = wr && in_win;
    assign buf_idx  = reg_addr[BI_W-1:2];
    assign cmd_v    = wr && (reg_addr == A_CMD);
    assign cmd_code = reg_wdata[3:0];
    assign cmd_cs   = reg_wdata[12 +: CS_W];

    always_comb begin
        rmux = '0;
        if (in_win) begin
            rmux = buf_rdata;
        end else begin
            case (reg_addr)
                A_INT_ST:  rmux = {30'd0, r_q.ist};
                A_INT_MSD: rmux = {30'd0, r_q.ist & r_q.msk};
                A_INT_MSK: rmux = {30'd0, r_q.msk};
                A_STAT:    rmux = {30'd0, armed, busy};
                A_MODE:    rmux = {r_q.pre, 24'd0};
                default:   rmux = '0;
            endcase
        end
    end

    always_comb begin
        r_d = r_q;
        if (rd) begin
            r_d.rdata = rmux;
        end
        if (wr && reg_addr == A_INT_MSK) begin
            r_d.msk = reg_wdata[1:0];
        end
        if (wr && reg_addr == A_MODE) begin
            r_d.pre = reg_wdata[31:24];
        end
        if (wr && reg_addr == A_INT_ST) begin
            r_d.ist = r_q.ist & ~reg_wdata[1:0];
        end
        // new events take precedence over a clear in the same cycle
        r_d.ist = r_d.ist | {rej_p, done_p};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata = r_q.rdata;
    assign irq       = |(r_q.ist & r_q.msk);
    assign prepend   = r_q.pre;
    assign int_st    = r_q.ist;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int NUM_CS    = 8,
    localparam int BI_W  = $clog2(BUF_BYTES),
    localparam int CNT_W = BI_W + 1,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_v,
    input  logic [3:0]        cmd_code,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic              ext_trig,
    input  logic              bit_tick,
    input  logic [15:0]       hdr,
    input  logic [7:0]        prepend,
    input  logic [7:0]        tx_byte,
    input  logic              miso,
    output logic [BI_W-1:0]   tx_idx,
    output logic              rx_we,
    output logic [BI_W-1:0]   rx_idx,
    output logic [7:0]        rx_byte,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy,
    output logic              armed,
    output logic              done_p,
    output logic              rej_p
);

    localparam logic [13:0] LIMIT = 14'(BUF_BYTES - 2);

    typedef struct packed {
        logic             run;
        logic             arm;
        logic             halt;
        logic             sck;
        logic [CS_W-1:0]  cs;
        logic [2:0]       op;
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bits;
        logic [7:0]       sr;
        logic [7:0]       rx;
    } seq_t;

    seq_t s_d, s_q;

    logic [2:0]       h_op;
    logic [12:0]      h_len;
    logic [7:0]       h_pre;
    logic [13:0]      h_sum;
    logic             h_ok;
    logic             go;
    logic [CNT_W-1:0] nxt;

    assign h_op  = hdr[15:13];
    assign h_len = hdr[12:0];
    assign h_pre = (h_op == OP_RECV) ? prepend : 8'd0;
    assign h_sum = {1'b0, h_len} + {6'd0, h_pre};
    assign h_ok  = (h_op == OP_XCHG || h_op == OP_SEND || h_op == OP_RECV)
                   && (h_len != 13'd0) && (h_sum <= LIMIT);
    assign go    = !s_q.run && ((cmd_v && cmd_code == CMD_GO) || (s_q.arm && ext_trig));
    assign nxt   = s_q.cnt + 1'b1;

    // before launch the first payload byte; afterwards the byte after cnt
    assign tx_idx = s_q.run ? BI_W'(s_q.cnt + CNT_W'(3)) : BI_W'(2);
    assign rx_idx = (s_q.op == OP_XCHG) ? BI_W'(s_q.cnt) : BI_W'(s_q.cnt - s_q.pre);

    always_comb begin
        s_d    = s_q;
        rx_we  = 1'b0;
        done_p = 1'b0;
        rej_p  = 1'b0;
        if (cmd_v && cmd_code == CMD_FLUSH) begin
            s_d = '0;
        end else begin
            if (cmd_v && cmd_code == CMD_HALT) begin
                s_d.arm = 1'b0;
                s_d.halt = s_q.run;
            end
            if (cmd_v && cmd_code == CMD_ARM && !s_q.run) begin
                s_d.arm = 1'b1;
                s_d.cs  = cmd_cs;
            end
            if (go) begin
                s_d.arm = 1'b0;
                if (h_ok) begin
                    s_d.run   = 1'b1;
                    s_d.halt  = 1'b0;
                    s_d.sck   = 1'b0;
                    s_d.cs    = (cmd_v && cmd_code == CMD_GO) ? cmd_cs : s_q.cs;
                    s_d.op    = h_op;
                    s_d.pre   = CNT_W'(h_pre);
                    s_d.total = CNT_W'(h_sum);
                    s_d.cnt   = '0;
                    s_d.bits  = '0;
                    s_d.sr    = (h_op != OP_RECV || h_pre != 8'd0) ? tx_byte : 8'd0;
                end else begin
                    rej_p = 1'b1;
                end
            end else if (s_q.run && bit_tick) begin
                if (!s_q.sck) begin
                    s_d.sck = 1'b1;
                    s_d.rx  = {s_q.rx[6:0], miso};
                end else begin
                    s_d.sck = 1'b0;
                    if (s_q.bits == 3'd7) begin
                        rx_we = (s_q.op == OP_XCHG) ||
                                (s_q.op == OP_RECV && s_q.cnt >= s_q.pre);
                        s_d.cnt  = nxt;
                        s_d.bits = '0;
                        if (nxt == s_q.total || s_q.halt) begin
                            s_d.run  = 1'b0;
                            s_d.halt = 1'b0;
                            done_p   = !s_q.halt;
                        end else begin
                            s_d.sr = (s_q.op != OP_RECV || nxt < s_q.pre) ? tx_byte : 8'd0;
                        end
                    end else begin
                        s_d.bits = s_q.bits + 1'b1;
                        s_d.sr   = {s_q.sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(s_q.run && s_q.cs == CS_W'(g));
    end

    assign rx_byte = s_q.rx;
    assign sck     = s_q.sck;
    assign mosi    = s_q.run && s_q.sr[7];
    assign busy    = s_q.run;
    assign armed   = s_q.arm;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int NUM_CS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              ext_trig,
    input  logic              bit_tick,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);

    localparam int BI_W = $clog2(BUF_BYTES);
    localparam int WI_W = BI_W - 2;
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [31:0]     buf_rdata;
    logic            buf_we;
    logic [WI_W-1:0] buf_idx;
    logic            eng_we;
    logic [BI_W-1:0] eng_widx, eng_ridx;
    logic [7:0]      eng_wbyte, eng_rbyte;
    logic [15:0]     hdr;
    logic            busy, armed, done_p, rej_p, cmd_v;
    logic [3:0]      cmd_code;
    logic [CS_W-1:0] cmd_cs;
    logic [7:0]      prepend;
    logic [1:0]      int_st;

    spi_cmd_buf #(.BUF_BYTES(BUF_BYTES)) buf_i (
        .clk(clk), .bus_we(buf_we), .bus_widx(buf_idx), .bus_wdata(reg_wdata),
        .bus_ridx(buf_idx), .bus_rdata(buf_rdata),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wbyte(eng_wbyte),
        .eng_ridx(eng_ridx), .eng_rbyte(eng_rbyte), .hdr(hdr)
    );

    spi_cmd_regs #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_idx(buf_idx),
        .busy(busy), .armed(armed), .done_p(done_p), .rej_p(rej_p),
        .cmd_v(cmd_v), .cmd_code(cmd_code), .cmd_cs(cmd_cs),
        .prepend(prepend), .int_st(int_st)
    );

    spi_cmd_seq #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_v(cmd_v), .cmd_code(cmd_code),
        .cmd_cs(cmd_cs), .ext_trig(ext_trig), .bit_tick(bit_tick),
        .hdr(hdr), .prepend(prepend), .tx_byte(eng_rbyte), .miso(spi_miso),
        .tx_idx(eng_ridx), .rx_we(eng_we), .rx_idx(eng_widx), .rx_byte(eng_wbyte),
        .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .busy(busy),
        .armed(armed), .done_p(done_p), .rej_p(rej_p)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              spi_sck,
    input logic              spi_mosi,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic [1:0]        int_st
);

    // R6: never more than one select line active
    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R6: the chosen select does not change during a transfer
    a_r6_select_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(spi_cs_n));

    // R1: an idle engine keeps the bus quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&spi_cs_n && !spi_sck && !spi_mosi));

    // R2: data out does not move while the clock stays high
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(spi_sck) && spi_sck) |-> $stable(spi_mosi));

    // R8: the done flag rises only as a running transfer ends
    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_st[0]) |-> ($past(busy) && !busy));

    // R7: a reject happens with no transfer on either side
    a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_st[1]) |-> (!$past(busy) && !busy));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .int_st(int_st)
);

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;

    localparam int BUF = 32;
    localparam int NCS = 8;

    // op, len, prepend, cs, seed
    localparam logic [39:0] VEC [7] = '{
        40'h02_03_00_00_11,
        40'h03_04_01_05_40,
        40'h01_05_00_07_80,
        40'h03_03_00_02_01,
        40'h02_1E_00_03_07,
        40'h03_1C_02_01_09,
        40'h01_02_03_04_33
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_en = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, ext_trig = 1'b0, bit_tick = 1'b1;
    logic spi_sck, spi_mosi, spi_miso = 1'b0;
    logic [NCS-1:0] spi_cs_n;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.BUF_BYTES(BUF), .NUM_CS(NCS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .ext_trig(ext_trig), .bit_tick(bit_tick),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int checks = 0, fails = 0;
    logic [7:0] img [BUF];

    // ---------------- slave model ----------------
    logic cs_any;
    assign cs_any = ~&spi_cs_n;
    int s_bits = 0, s_bytes = 0, cs_count = 0;
    logic [7:0] s_in = '0, s_out = '0;
    logic [NCS-1:0] cs_seen = '1;
    logic [7:0] mosi_log [64];

    function automatic logic [7:0] miso_byte(input int i);
        return 8'h5A ^ 8'(i * 13);
    endfunction

    always @(posedge cs_any) begin
        s_bits = 0; s_bytes = 0; cs_count++;
        cs_seen = spi_cs_n;
        s_out = miso_byte(0);
        spi_miso = s_out[7];
    end

    always @(posedge spi_sck) if (cs_any) begin
        s_in = {s_in[6:0], spi_mosi};
        s_bits++;
        if (s_bits == 8) begin
            if (s_bytes < 64) mosi_log[s_bytes] = s_in;
            s_bytes++;
            s_bits = 0;
        end
    end

    always @(negedge spi_sck) if (cs_any) begin
        if (s_bits == 0) s_out = miso_byte(s_bytes);
        else             s_out = {s_out[6:0], 1'b0};
        spi_miso = s_out[7];
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd_byte(input int idx, output logic [7:0] b);
        logic [31:0] w;
        rd(12'h200 + 12'(idx & ~3), w);
        b = w[8*(idx & 3) +: 8];
    endtask

    task automatic wait_idle();
        logic [31:0] w;
        for (int n = 0; n < 3000; n++) begin
            rd(12'h084, w);
            if (!w[0]) return;
        end
        check(1'b0, "R6", "busy never cleared", 1, 0);
    endtask

    task automatic set_image(input int op, input int len, input int seed);
        img[0] = 8'(len);
        img[1] = {3'(op), 5'(len >> 8)};
        for (int i = 2; i < BUF; i++) img[i] = 8'(seed + 3 * (i - 2));
        for (int w = 0; w < BUF / 4; w++)
            wr(12'h200 + 12'(4 * w), {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
    endtask

    task automatic go(input int cs);
        wr(12'h080, 32'((cs << 12) | 1));
    endtask

    // ---------------- vector run ----------------
    task automatic run_vec(input logic [39:0] v);
        int op, len, pre, cs, seed, total, bad, first_a, first_e;
        logic [31:0] w;
        logic [7:0] b;
        op = int'(v[39:32]); len = int'(v[31:24]); pre = int'(v[23:16]);
        cs = int'(v[15:8]); seed = int'(v[7:0]);
        set_image(op, len, seed);
        wr(12'h088, 32'(pre << 24));
        wr(12'h008, 32'h3);
        go(cs);
        wait_idle();
        total = (op == 3) ? pre + len : len;
        // R6 select line, R5 header decode via byte count
        check(cs_seen == ~NCS'(1 << cs), "R6", "select line", int'(cs_seen), int'(~NCS'(1 << cs)));
        check(s_bytes == total, "R5", "byte count", s_bytes, total);
        bad = 0; first_a = 0; first_e = 0;
        for (int i = 0; i < total; i++) begin
            logic [7:0] e;
            e = (op == 3 && i >= pre) ? 8'h00 : img[2 + i];
            if (mosi_log[i] != e && bad++ == 0) begin first_a = mosi_log[i]; first_e = e; end
        end
        check(bad == 0, (op == 2) ? "R2" : (op == 3) ? "R3" : "R4", "MOSI bytes", first_a, first_e);
        bad = 0;
        if (op == 2) begin
            rd(12'h200, w);
            check(w == {img[3], img[2], img[1], img[0]}, "R2", "buffer untouched", int'(w),
                  int'({img[3], img[2], img[1], img[0]}));
        end else begin
            for (int i = 0; i < len; i++) begin
                logic [7:0] e;
                e = miso_byte((op == 3) ? pre + i : i);
                rd_byte(i, b);
                if (b != e && bad++ == 0) begin first_a = b; first_e = e; end
            end
            check(bad == 0, (op == 3) ? "R3" : "R4", "received bytes", first_a, first_e);
        end
        rd(12'h008, w);
        check(w == 32'h1, "R8", "done flag", int'(w), 1);
    endtask

    task automatic expect_reject(input int op, input int len, input int pre, input string what);
        int c0;
        logic [31:0] w;
        set_image(op, len, 0);
        wr(12'h088, 32'(pre << 24));
        wr(12'h008, 32'h3);
        c0 = cs_count;
        go(2);
        repeat (4) @(negedge clk);
        rd(12'h008, w);
        check(w == 32'h2 && cs_count == c0, "R7", what, int'(w), 2);
    endtask

    // ---------------- main ----------------
    initial begin
        logic [31:0] w;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(spi_cs_n == '1 && !spi_sck && !spi_mosi && !irq, "R1", "pins after reset",
              int'({spi_cs_n, spi_sck, spi_mosi, irq}), int'({NCS'('1), 3'b000}));
        rd(12'h084, w); check(w == 0, "R1", "status word", int'(w), 0);
        rd(12'h008, w); check(w == 0, "R1", "interrupt status", int'(w), 0);

        for (int v = 0; v < 7; v++) run_vec(VEC[v]);

        // R7 rejects at and past the limit
        expect_reject(2, 31, 0, "length past limit");
        expect_reject(3, 29, 2, "prepend plus length past limit");
        expect_reject(0, 3, 0, "opcode 0");
        expect_reject(5, 3, 0, "opcode 5");
        expect_reject(2, 0, 0, "zero length");

        // R8 mask, masked status, irq, write-one-to-clear
        run_vec(40'h02_02_00_00_21);
        wr(12'h010, 32'h0);
        rd(12'h00C, w); check(w == 0 && !irq, "R8", "masked off", int'(w), 0);
        wr(12'h010, 32'h1);
        rd(12'h00C, w); check(w == 1 && irq, "R8", "masked on", int'({w[0], irq}), 3);
        wr(12'h008, 32'h1);
        rd(12'h008, w); check(w == 0 && !irq, "R8", "cleared", int'({w[0], irq}), 0);
        wr(12'h010, 32'h0);

        // R9 start on trigger
        set_image(2, 3, 8'h60);
        c0 = cs_count;
        wr(12'h080, 32'((6 << 12) | 2));
        rd(12'h084, w); check(w == 2, "R9", "armed bit", int'(w), 2);
        repeat (10) @(negedge clk);
        check(cs_count == c0, "R9", "no start before trigger", cs_count, c0);
        ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        wait_idle();
        check(cs_seen == ~NCS'(1 << 6) && s_bytes == 3, "R9", "triggered transfer",
              s_bytes, 3);
        rd(12'h084, w); check(w == 0, "R9", "armed cleared", int'(w), 0);

        // R10 halt finishes the byte in flight (byte 2)
        set_image(2, 10, 8'h10);
        wr(12'h008, 32'h3);
        go(0);
        repeat (38) @(negedge clk);
        wr(12'h080, 32'h3);
        wait_idle();
        check(s_bytes == 3, "R10", "bytes before halt", s_bytes, 3);
        rd(12'h008, w); check(w == 0, "R10", "no done flag", int'(w), 0);

        // R11 flush is immediate
        go(1);
        repeat (20) @(negedge clk);
        wr(12'h080, 32'h4);
        check(spi_cs_n == '1 && !spi_sck, "R11", "lines released",
              int'({spi_cs_n, spi_sck}), int'({NCS'('1), 1'b0}));
        check(s_bytes == 1, "R11", "bytes before flush", s_bytes, 1);
        rd(12'h084, w); check(w == 0, "R11", "idle after flush", int'(w), 0);
        wr(12'h080, 32'((3 << 12) | 2));
        wr(12'h080, 32'h4);
        rd(12'h084, w); check(w == 0, "R11", "arm cleared", int'(w), 0);
        c0 = cs_count;
        ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        repeat (5) @(negedge clk);
        check(cs_count == c0, "R11", "trigger after flush", cs_count, c0);

        // R12 start while busy and no-op
        set_image(2, 4, 8'h70);
        c0 = cs_count;
        go(0);
        go(3);
        wait_idle();
        check(cs_count == c0 + 1 && cs_seen == ~NCS'(1) && s_bytes == 4, "R12",
              "second start ignored", cs_count - c0, 1);
        wr(12'h008, 32'h3);
        c0 = cs_count;
        wr(12'h080, 32'h0);
        repeat (4) @(negedge clk);
        rd(12'h008, w);
        check(cs_count == c0 && w == 0, "R12", "no-op", cs_count - c0, 0);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule